// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the 32-bit status and control word of one root port of a USB host controller. It shows the port's live condition (attached device, enable, over-current, reset in progress, power, link state and negotiated speed) and keeps a set of sticky change flags. Software clears these flags by writing ones to them. Software can also set the port's power, indicator and wake-enable bits. It can request a link state change, and it can start a hot or a warm port reset.

A simplified port model sits on the port side. It reports attach, over-current, link state updates, the speed found during reset, and the end of a reset. It also reports a cold attach and a link configuration error. The register drives the reset requests and the software link-state requests back to that model. Every register write carries a full 32-bit word. Fields that are read-only or read-as-zero ignore the bits written to them.

Top module: `rport_status_ctl`

## Requirements
- R1: After reset the word reads 0x0000_02A0: power (bit 9) set, link state RxDetect (code 5) in bits 8:5, all else zero. Bits 2, 16, 28 and 29 always read as zero.
- R2: Bit 0 follows the attach input and bit 3 follows the over-current input, each one cycle late. Every change of bit 0 sets the connect-change flag (bit 17). Every change of bit 3 sets the over-current-change flag (bit 20).
- R3: The link state field is bits 8:5. A write changes it only when bit 16 of the same write is 1, and it then raises a one-cycle request carrying the written code. A port-side link update in the same cycle wins, and the software request is dropped.
- R4: The link-change flag (bit 22) is set when the field moves U3(3)→Resume(15), U3→U0(0), Resume→U0, U2(2)→U0, U0→Disabled(4), or from any other state into Inactive(6). No other move sets it, except the one covered by R5.
- R5: A move Recovery(8)→U0 sets bit 22 only when the field entered Recovery from Resume or from U3.
- R6: Writing 1 to bit 4 starts a hot reset. Bit 4 reads 1 and the hot request output is high until the port reports reset done. At that edge bit 4 clears, the reset-change flag (bit 21) sets, enable (bit 1) takes the attach input, and the speed is latched.
- R7: Writing 1 to bit 31 starts a warm reset. Bit 31 and bit 4 read 1 and the warm request output is high. On reset done, both flags 19 and 21 set, and cold-attach status (bit 24) clears.
- R8: The change flags sit in bits 23:17 in the order connect, enable, warm reset, over-current, reset, link, config error. Writing 1 clears a flag. Writing 0 leaves it as it is. An event in the same cycle as a clear leaves the flag set.
- R9: When an attached device goes away, enable clears and the speed becomes 0. The enable-change flag (bit 18) sets if the port had been enabled.
- R10: Bits 13:10 latch the speed code (1 full, 2 low, 3 high, 4 SuperSpeed, 5 SuperSpeedPlus) at reset completion when a device is attached. Codes above the highest valid code, and any completion with no device attached, store 0.
- R11: Bit 9 (power) and bits 27:25 (wake on connect, disconnect, over-current) take the written value on every write. The indicator field in bits 15:14 takes the values 0 off, 1 amber and 2 green, and a write of 3 leaves it unchanged. Bit 30 reads the non-removable parameter. The outputs mirror power and indicator.
- R12: A cold-attach pulse sets bit 24. A config-error pulse sets flag bit 23.
- R13: Reset writes made while a reset is already in progress are ignored. A write with both bits 4 and 31 set starts a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write enable |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read value |
| port_conn_i | input | 1 | Device attached |
| port_oc_i | input | 1 | Over-current present |
| port_ls_vld_i | input | 1 | Port-side link state update valid |
| port_ls_i | input | 4 | Port-side link state code |
| port_speed_i | input | 4 | Speed found by the port during reset |
| port_rst_done_i | input | 1 | Reset finished pulse |
| port_cold_att_i | input | 1 | Cold attach detected pulse |
| port_cfg_err_i | input | 1 | Link configuration error pulse |
| hot_rst_o | output | 1 | Hot reset request to the port |
| warm_rst_o | output | 1 | Warm reset request to the port |
| ls_req_vld_o | output | 1 | Software link state request pulse |
| ls_req_o | output | 4 | Requested link state code |
| pwr_en_o | output | 1 | Port power enable |
| led_o | output | 2 | Indicator colour |

## Verification
The bench builds the block with its default parameters: highest valid speed code 5, power on after reset, removable device, and origin checking on the Recovery→U0 move. Because origin checking is on, the bench can contrast Recovery→U0 after Resume with the same move after U0, and show that only the first raises the link flag. With the speed limit at 5, a reported code 7 exercises the reserved-code path, and code 4 exercises a normal latch. The bench compares every field against a behavioural model on every clock. It drives the collisions directly: an event against a clear, a port link update against a strobed write, and a reset write against a reset already running.

// File: rtl/rps_pkg.sv
package rps_pkg;
   localparam int unsigned LS_W    = 4;
   localparam int unsigned N_CHG   = 7;
   localparam int unsigned CHG_LSB = 17;

   localparam logic [LS_W-1:0] LS_U0     = 4'd0;
   localparam logic [LS_W-1:0] LS_U1     = 4'd1;
   localparam logic [LS_W-1:0] LS_U2     = 4'd2;
   localparam logic [LS_W-1:0] LS_U3     = 4'd3;
   localparam logic [LS_W-1:0] LS_DIS    = 4'd4;
   localparam logic [LS_W-1:0] LS_RXDET  = 4'd5;
   localparam logic [LS_W-1:0] LS_INACT  = 4'd6;
   localparam logic [LS_W-1:0] LS_RECOV  = 4'd8;
   localparam logic [LS_W-1:0] LS_RESUME = 4'd15;

   // change flag index inside the change field
   localparam int unsigned CF_CONN = 0;
   localparam int unsigned CF_EN   = 1;
   localparam int unsigned CF_WARM = 2;
   localparam int unsigned CF_OC   = 3;
   localparam int unsigned CF_RST  = 4;
   localparam int unsigned CF_LINK = 5;
   localparam int unsigned CF_CFG  = 6;

   // bit positions in the status word
   localparam int unsigned B_CONN   = 0;
   localparam int unsigned B_EN     = 1;
   localparam int unsigned B_OC     = 3;
   localparam int unsigned B_RST    = 4;
   localparam int unsigned B_LS_LO  = 5;
   localparam int unsigned B_PWR    = 9;
   localparam int unsigned B_SPD_LO = 10;
   localparam int unsigned B_LED_LO = 14;
   localparam int unsigned B_STROBE = 16;
   localparam int unsigned B_CAS    = 24;
   localparam int unsigned B_WK_LO  = 25;
   localparam int unsigned B_NREM   = 30;
   localparam int unsigned B_WARM   = 31;
endpackage

// File: rtl/rps_chg_flags.sv
module rps_chg_flags #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flg_o
);
   if (N < 1) begin : g_bad_n
      $error("rps_chg_flags: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          q <= 1'b0;
         else if (evt_i[g])   q <= 1'b1;
         else if (clr_i[g])   q <= 1'b0;
      end
      assign flg_o[g] = q;
   end
endmodule

// File: rtl/rps_link_track.sv
module rps_link_track import rps_pkg::*; #(
   parameter int unsigned W            = 4,
   parameter bit          ORIGIN_CHECK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ls_q_i,
   input  logic [W-1:0] ls_d_i,
   output logic         plc_evt_o
);
   if (W != LS_W) begin : g_bad_w
      $error("rps_link_track: W must equal the link state width");
   end

   logic [W-1:0] org_q;
   logic         via_ok;
   logic         moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         org_q <= LS_RXDET;
      else if (ls_d_i == LS_RECOV && ls_q_i != LS_RECOV)
         org_q <= ls_q_i;
   end

   if (ORIGIN_CHECK) begin : g_origin
      assign via_ok = (org_q == LS_RESUME) || (org_q == LS_U3);
   end else begin : g_any
      assign via_ok = 1'b1;
   end

   assign moved = (ls_d_i != ls_q_i);

   always_comb begin
      plc_evt_o = 1'b0;
      if (moved) begin
         if (ls_d_i == LS_INACT)                                   plc_evt_o = 1'b1;
         if (ls_q_i == LS_U3 && (ls_d_i == LS_RESUME || ls_d_i == LS_U0)) plc_evt_o = 1'b1;
         if (ls_q_i == LS_RESUME && ls_d_i == LS_U0)               plc_evt_o = 1'b1;
         if (ls_q_i == LS_U2 && ls_d_i == LS_U0)                   plc_evt_o = 1'b1;
         if (ls_q_i == LS_U0 && ls_d_i == LS_DIS)                  plc_evt_o = 1'b1;
         if (ls_q_i == LS_RECOV && ls_d_i == LS_U0 && via_ok)      plc_evt_o = 1'b1;
      end
   end
endmodule

// File: rtl/rps_reset_seq.sv
module rps_reset_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_req_i,
   input  logic warm_req_i,
   input  logic done_i,
   output logic busy_o,
   output logic warm_o,
   output logic fin_o,
   output logic warm_fin_o
);
   logic busy_q, warm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         warm_q <= 1'b0;
      end else if (busy_q) begin
         if (done_i) begin
            busy_q <= 1'b0;
            warm_q <= 1'b0;
         end
      end else if (warm_req_i) begin
         busy_q <= 1'b1;
         warm_q <= 1'b1;
      end else if (hot_req_i) begin
         busy_q <= 1'b1;
      end
   end

   assign busy_o     = busy_q;
   assign warm_o     = warm_q;
   assign fin_o      = busy_q & done_i;
   assign warm_fin_o = busy_q & warm_q & done_i;
endmodule

// File: rtl/rport_status_ctl.sv
module rport_status_ctl import rps_pkg::*; #(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SPD_W         = 4,
   parameter int unsigned MAX_SPEED     = 5,
   parameter bit          PWR_RST       = 1'b1,
   parameter bit          NON_REMOVABLE = 1'b0,
   parameter bit          ORIGIN_CHECK  = 1'b1,
   parameter int unsigned LS_RST        = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              port_conn_i,
   input  logic              port_oc_i,
   input  logic              port_ls_vld_i,
   input  logic [3:0]        port_ls_i,
   input  logic [SPD_W-1:0]  port_speed_i,
   input  logic              port_rst_done_i,
   input  logic              port_cold_att_i,
   input  logic              port_cfg_err_i,
   output logic              hot_rst_o,
   output logic              warm_rst_o,
   output logic              ls_req_vld_o,
   output logic [3:0]        ls_req_o,
   output logic              pwr_en_o,
   output logic [1:0]        led_o
);
   localparam int unsigned LED_W  = 2;
   localparam int unsigned WK_W   = 3;
   localparam logic [LED_W-1:0] LED_BAD = {LED_W{1'b1}};

   if (DATA_W != 32) begin : g_bad_dw
      $error("rport_status_ctl: DATA_W must be 32");
   end
   if (SPD_W != 4) begin : g_bad_sw
      $error("rport_status_ctl: SPD_W must be 4");
   end
   if (MAX_SPEED > 15 || MAX_SPEED < 1) begin : g_bad_ms
      $error("rport_status_ctl: MAX_SPEED out of range");
   end
   if (LS_RST > 15) begin : g_bad_lr
      $error("rport_status_ctl: LS_RST out of range");
   end

   logic              ccs_q, oc_q, pe_q, pp_q, cas_q;
   logic [LS_W-1:0]   ls_q, ls_d;
   logic [SPD_W-1:0]  spd_q;
   logic [LED_W-1:0]  led_q;
   logic [WK_W-1:0]   wk_q;
   logic [N_CHG-1:0]  chg_evt, chg_clr, chg_q;
   logic              strobe_wr, disc, plc_evt;
   logic              rs_busy, rs_warm, rs_fin, rs_warm_fin;
   logic              spd_ok;
   logic              lsr_vld_q;
   logic [LS_W-1:0]   lsr_q;

   // link state field: port update wins over a strobed software write
   assign strobe_wr = reg_wr_i & reg_wdata_i[B_STROBE];
   always_comb begin
      if (port_ls_vld_i)  ls_d = port_ls_i;
      else if (strobe_wr) ls_d = reg_wdata_i[B_LS_LO +: LS_W];
      else                ls_d = ls_q;
   end

   rps_link_track #(
      .W            (LS_W),
      .ORIGIN_CHECK (ORIGIN_CHECK)
   ) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .ls_q_i    (ls_q),
      .ls_d_i    (ls_d),
      .plc_evt_o (plc_evt)
   );

   rps_reset_seq u_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .hot_req_i  (reg_wr_i & reg_wdata_i[B_RST]),
      .warm_req_i (reg_wr_i & reg_wdata_i[B_WARM]),
      .done_i     (port_rst_done_i),
      .busy_o     (rs_busy),
      .warm_o     (rs_warm),
      .fin_o      (rs_fin),
      .warm_fin_o (rs_warm_fin)
   );

   assign disc   = ccs_q & ~port_conn_i;
   assign spd_ok = (port_speed_i <= SPD_W'(MAX_SPEED));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ccs_q     <= 1'b0;
         oc_q      <= 1'b0;
         pe_q      <= 1'b0;
         ls_q      <= LS_W'(LS_RST);
         spd_q     <= '0;
         cas_q     <= 1'b0;
         lsr_vld_q <= 1'b0;
         lsr_q     <= '0;
      end else begin
         ccs_q <= port_conn_i;
         oc_q  <= port_oc_i;
         ls_q  <= ls_d;
         if (rs_fin)    pe_q <= port_conn_i;
         else if (disc) pe_q <= 1'b0;
         if (rs_fin)    spd_q <= (port_conn_i && spd_ok) ? port_speed_i : '0;
         else if (disc) spd_q <= '0;
         if (port_cold_att_i)  cas_q <= 1'b1;
         else if (rs_warm_fin) cas_q <= 1'b0;
         lsr_vld_q <= strobe_wr & ~port_ls_vld_i;
         if (strobe_wr && !port_ls_vld_i) lsr_q <= reg_wdata_i[B_LS_LO +: LS_W];
      end
   end

   // software-owned fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp_q  <= PWR_RST;
         led_q <= '0;
         wk_q  <= '0;
      end else if (reg_wr_i) begin
         pp_q <= reg_wdata_i[B_PWR];
         wk_q <= reg_wdata_i[B_WK_LO +: WK_W];
         if (reg_wdata_i[B_LED_LO +: LED_W] != LED_BAD)
            led_q <= reg_wdata_i[B_LED_LO +: LED_W];
      end
   end

   always_comb begin
      chg_evt          = '0;
      chg_evt[CF_CONN] = port_conn_i ^ ccs_q;
      chg_evt[CF_EN]   = pe_q & disc;
      chg_evt[CF_WARM] = rs_warm_fin;
      chg_evt[CF_OC]   = port_oc_i ^ oc_q;
      chg_evt[CF_RST]  = rs_fin;
      chg_evt[CF_LINK] = plc_evt;
      chg_evt[CF_CFG]  = port_cfg_err_i;
   end
   assign chg_clr = reg_wr_i ? reg_wdata_i[CHG_LSB +: N_CHG] : '0;

   rps_chg_flags #(.N(N_CHG)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (chg_evt),
      .clr_i (chg_clr),
      .flg_o (chg_q)
   );

   always_comb begin
      reg_rdata_o                         = '0;
      reg_rdata_o[B_CONN]                 = ccs_q;
      reg_rdata_o[B_EN]                   = pe_q;
      reg_rdata_o[B_OC]                   = oc_q;
      reg_rdata_o[B_RST]                  = rs_busy;
      reg_rdata_o[B_LS_LO +: LS_W]        = ls_q;
      reg_rdata_o[B_PWR]                  = pp_q;
      reg_rdata_o[B_SPD_LO +: SPD_W]      = spd_q;
      reg_rdata_o[B_LED_LO +: LED_W]      = led_q;
      reg_rdata_o[CHG_LSB +: N_CHG]       = chg_q;
      reg_rdata_o[B_CAS]                  = cas_q;
      reg_rdata_o[B_WK_LO +: WK_W]        = wk_q;
      reg_rdata_o[B_NREM]                 = NON_REMOVABLE;
      reg_rdata_o[B_WARM]                 = rs_warm;
   end

   assign hot_rst_o    = rs_busy & ~rs_warm;
   assign warm_rst_o   = rs_busy & rs_warm;
   assign ls_req_vld_o = lsr_vld_q;
   assign ls_req_o     = lsr_q;
   assign pwr_en_o     = pp_q;
   assign led_o        = led_q;
endmodule

// File: rtl/rport_status_ctl_chk.sv
module rport_status_ctl_chk #(
   parameter int unsigned MAX_SPEED = 5
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_i,
   input logic [31:0] reg_wdata_i,
   input logic [31:0] reg_rdata_o,
   input logic        port_ls_vld_i,
   input logic        hot_rst_o,
   input logic        warm_rst_o
);
   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[2] == 1'b0 && reg_rdata_o[16] == 1'b0 && reg_rdata_o[29:28] == 2'b00);

   p_ls_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && !reg_wdata_i[16] && !port_ls_vld_i) |=> $stable(reg_rdata_o[8:5]));

   p_rst_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata_o[4]) |-> reg_rdata_o[21]);

   p_rst_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hot_rst_o && warm_rst_o));

   p_warm_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata_o[31]) |-> reg_rdata_o[19]);

   p_chg_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_i |=> ((reg_rdata_o[23:17] & $past(reg_rdata_o[23:17])) == $past(reg_rdata_o[23:17])));

   p_disc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata_o[0]) |-> (!reg_rdata_o[1] && reg_rdata_o[13:10] == 4'd0));

   p_spd_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata_o[13:10] <= 4'(MAX_SPEED));
endmodule

bind rport_status_ctl rport_status_ctl_chk #(.MAX_SPEED(MAX_SPEED)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr_i      (reg_wr_i),
   .reg_wdata_i   (reg_wdata_i),
   .reg_rdata_o   (reg_rdata_o),
   .port_ls_vld_i (port_ls_vld_i),
   .hot_rst_o     (hot_rst_o),
   .warm_rst_o    (warm_rst_o)
);

// File: tb/rport_status_ctl_tb.sv
`timescale 1ns/1ps
module rport_status_ctl_tb;
   localparam int PER = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        conn = 0, oc = 0, ls_vld = 0, rst_done = 0, cold = 0, cfg_err = 0;
   logic [3:0]  ls_in = '0, spd_in = '0;
   logic        hot_o, warm_o, lsr_vld, pwr_o;
   logic [3:0]  lsr;
   logic [1:0]  led;

   int n_chk = 0;
   int n_fail = 0;

   always #(PER/2) clk = ~clk;

   rport_status_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .port_conn_i(conn), .port_oc_i(oc), .port_ls_vld_i(ls_vld), .port_ls_i(ls_in),
      .port_speed_i(spd_in), .port_rst_done_i(rst_done), .port_cold_att_i(cold),
      .port_cfg_err_i(cfg_err), .hot_rst_o(hot_o), .warm_rst_o(warm_o),
      .ls_req_vld_o(lsr_vld), .ls_req_o(lsr), .pwr_en_o(pwr_o), .led_o(led)
   );

   // ---------------- behavioural reference model ----------------
   bit       m_ccs, m_oc, m_pe, m_busy, m_warm, m_pp, m_cas, m_lsv;
   int       m_ls, m_org, m_spd, m_led, m_wk, m_lsr;
   bit [6:0] m_chg;

   function automatic bit link_flag(int a, int b, int org);
      if (a == b) return 0;
      if (b == 6) return 1;
      case ({a[3:0], b[3:0]})
         8'h3F, 8'h30, 8'hF0, 8'h20, 8'h04: return 1;
         8'h80: return (org == 15 || org == 3);
         default: return 0;
      endcase
   endfunction

   task automatic model_step();
      int  nls;
      bit  plc, fin, dsc;
      bit [6:0] ev;
      if (!rst_n) begin
         m_ccs = 0; m_oc = 0; m_pe = 0; m_busy = 0; m_warm = 0; m_pp = 1; m_cas = 0;
         m_ls = 5; m_org = 5; m_spd = 0; m_led = 0; m_wk = 0; m_chg = '0;
         m_lsv = 0; m_lsr = 0;
         return;
      end
      nls = m_ls;
      if (ls_vld) nls = ls_in;
      else if (reg_wr && wdata[16]) nls = wdata[8:5];
      plc = link_flag(m_ls, nls, m_org);
      if (nls == 8 && m_ls != 8) m_org = m_ls;
      fin = m_busy && rst_done;
      dsc = m_ccs && !conn;
      ev[0] = conn != m_ccs;
      ev[1] = m_pe && dsc;
      ev[2] = fin && m_warm;
      ev[3] = oc != m_oc;
      ev[4] = fin;
      ev[5] = plc;
      ev[6] = cfg_err;
      for (int i = 0; i < 7; i++)
         if (ev[i]) m_chg[i] = 1;
         else if (reg_wr && wdata[17+i]) m_chg[i] = 0;
      if (fin) m_pe = conn; else if (dsc) m_pe = 0;
      if (fin) m_spd = (conn && spd_in <= 5) ? int'(spd_in) : 0;
      else if (dsc) m_spd = 0;
      if (cold) m_cas = 1; else if (fin && m_warm) m_cas = 0;
      if (m_busy) begin
         if (rst_done) begin m_busy = 0; m_warm = 0; end
      end else if (reg_wr && wdata[31]) begin m_busy = 1; m_warm = 1; end
      else if (reg_wr && wdata[4]) m_busy = 1;
      m_ccs = conn; m_oc = oc;
      if (reg_wr) begin
         m_pp = wdata[9]; m_wk = wdata[27:25];
         if (wdata[15:14] != 2'b11) m_led = wdata[15:14];
      end
      m_lsv = reg_wr && wdata[16] && !ls_vld;
      if (m_lsv) m_lsr = wdata[8:5];
      m_ls = nls;
   endtask

   task automatic cmp(input string tag, input string nm, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      cmp("R2", "connect", rdata[0], m_ccs);
      cmp("R2", "overcurrent", rdata[3], m_oc);
      cmp("R6 R9", "enable", rdata[1], m_pe);
      cmp("R6 R13", "reset busy", rdata[4], m_busy);
      cmp("R7 R13", "warm busy", rdata[31], m_warm);
      cmp("R3", "link state", rdata[8:5], m_ls);
      cmp("R11", "power", rdata[9], m_pp);
      cmp("R10", "speed", rdata[13:10], m_spd);
      cmp("R11", "indicator", rdata[15:14], m_led);
      cmp("R2 R8", "conn chg", rdata[17], m_chg[0]);
      cmp("R9 R8", "enable chg", rdata[18], m_chg[1]);
      cmp("R7 R8", "warm chg", rdata[19], m_chg[2]);
      cmp("R2 R8", "oc chg", rdata[20], m_chg[3]);
      cmp("R6 R8", "reset chg", rdata[21], m_chg[4]);
      cmp("R4 R5", "link chg", rdata[22], m_chg[5]);
      cmp("R12 R8", "cfg chg", rdata[23], m_chg[6]);
      cmp("R12", "cold attach", rdata[24], m_cas);
      cmp("R11", "wake", rdata[27:25], m_wk);
      cmp("R11", "non-removable", rdata[30], 0);
      cmp("R1", "zero bits", {rdata[29:28], rdata[16], rdata[2]}, 0);
      cmp("R6", "hot out", hot_o, m_busy && !m_warm);
      cmp("R7", "warm out", warm_o, m_busy && m_warm);
      cmp("R3", "req valid", lsr_vld, m_lsv);
      if (m_lsv) cmp("R3", "req code", lsr, m_lsr);
      cmp("R11", "power out", pwr_o, m_pp);
      cmp("R11", "led out", led, m_led);
   endtask

   always @(posedge clk) begin
      model_step();
      #2 compare_all();
   end

   // ---------------- stimulus ----------------
   localparam logic [31:0] PWR = 32'h0000_0200;

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] w);
      @(negedge clk); reg_wr = 1; wdata = w;
      @(negedge clk); reg_wr = 0; wdata = '0;
   endtask

   task automatic port_ls(input logic [3:0] c);
      @(negedge clk); ls_vld = 1; ls_in = c;
      @(negedge clk); ls_vld = 0;
   endtask

   function automatic logic [31:0] lsw(input logic [3:0] c);
      return PWR | 32'h0001_0000 | (32'(c) << 5);
   endfunction

   task automatic reset_done(input logic [3:0] s);
      @(negedge clk); rst_done = 1; spd_in = s;
      @(negedge clk); rst_done = 0;
   endtask

   initial begin
      #(PER * 150000);
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      cmp("R1", "reset word", rdata, 32'h0000_02A0);

      // R2: attach, then W1C the connect flag
      @(negedge clk); conn = 1;
      idle(2);
      cmp("R2", "conn flag set", rdata[17], 1);
      wr(PWR | 32'h0002_0000);
      cmp("R8", "conn flag cleared", rdata[17], 0);

      // R6/R13: hot reset, a warm write during it is ignored
      wr(PWR | 32'h0000_0010);
      cmp("R6", "hot request", hot_o, 1);
      wr(PWR | 32'h8000_0000);
      cmp("R13", "no warm while busy", warm_o, 0);
      reset_done(4'd4);
      cmp("R6", "enabled after reset", rdata[1], 1);
      cmp("R10", "speed latched", rdata[13:10], 4);

      // R3: link write without strobe ignored, with strobe taken
      wr(PWR | (32'd3 << 5));
      cmp("R3", "no strobe", rdata[8:5], 5);
      wr(lsw(4'd0)); wr(lsw(4'd3));
      cmp("R3", "strobe write", rdata[8:5], 3);
      wr(lsw(4'd0));
      cmp("R4", "U3 to U0", rdata[22], 1);
      wr(PWR | 32'h0040_0000);
      port_ls(4'd3); port_ls(4'd15);
      cmp("R4", "U3 to Resume", rdata[22], 1);
      wr(PWR | 32'h0040_0000);
      port_ls(4'd8); port_ls(4'd0);
      cmp("R5", "Resume via Recovery", rdata[22], 1);
      wr(PWR | 32'h0040_0000);
      port_ls(4'd8); port_ls(4'd0);
      cmp("R5", "U0 via Recovery no flag", rdata[22], 0);
      port_ls(4'd1); port_ls(4'd2); port_ls(4'd0);
      cmp("R4", "U2 to U0", rdata[22], 1);
      wr(PWR | 32'h0040_0000);
      port_ls(4'd4);
      cmp("R4", "U0 to Disabled", rdata[22], 1);
      wr(PWR | 32'h0040_0000);
      port_ls(4'd7); port_ls(4'd6);
      cmp("R4", "to Inactive", rdata[22], 1);

      // R3: port update same cycle as strobed write wins
      @(negedge clk); ls_vld = 1; ls_in = 4'd0; reg_wr = 1; wdata = lsw(4'd3);
      @(negedge clk); ls_vld = 0; reg_wr = 0; wdata = '0;
      cmp("R3", "port wins", rdata[8:5], 0);

      // R8: event in the same cycle as a clear keeps the flag
      @(negedge clk); oc = 1;
      @(negedge clk); oc = 0; reg_wr = 1; wdata = PWR | 32'h0010_0000;
      @(negedge clk); reg_wr = 0; wdata = '0;
      cmp("R8", "event beats clear", rdata[20], 1);
      wr(PWR);
      cmp("R8", "zero write keeps", rdata[20], 1);

      // R12 / R7 / R10: cold attach, warm reset with a reserved speed
      @(negedge clk); cold = 1; cfg_err = 1;
      @(negedge clk); cold = 0; cfg_err = 0;
      cmp("R12", "cold attach set", rdata[24], 1);
      cmp("R12", "cfg flag set", rdata[23], 1);
      wr(PWR | 32'h8000_0010);
      cmp("R7", "warm request", warm_o, 1);
      reset_done(4'd7);
      cmp("R7", "warm flag", rdata[19], 1);
      cmp("R7", "cold attach cleared", rdata[24], 0);
      cmp("R10", "reserved speed", rdata[13:10], 0);

      // R11: indicator, wake, power
      wr(PWR | 32'h0000_4000 | 32'h0A00_0000);
      cmp("R11", "amber", led, 1);
      wr(PWR | 32'h0000_8000);
      cmp("R11", "green", led, 2);
      wr(32'h0000_C000);
      cmp("R11", "value 3 ignored", led, 2);
      cmp("R11", "power off", pwr_o, 0);

      // R9: detach while enabled
      wr(PWR | 32'h0000_0010);
      reset_done(4'd3);
      wr(PWR | 32'h00FE_0000);
      @(negedge clk); conn = 0;
      idle(2);
      cmp("R9", "enable cleared", rdata[1], 0);
      cmp("R9", "enable flag", rdata[18], 1);
      cmp("R9", "speed zero", rdata[13:10], 0);
      idle(4);

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule